// File: doc/BRIEF.md
# Serial EEPROM Word Write Sequencer

This block turns one host write request into the complete bit-serial exchange that a three-wire serial EEPROM-style register array needs to store a 16-bit word. The wires are chip select, serial clock and data-out. The host presents an address and a data word with a one-cycle start strobe. The sequencer then runs three framed transactions in a fixed order. First it opens the array for writing. Then it sends the write command with the address and data. Last it closes the array for writing again.

Each transaction raises chip select and waits a settling time with the clock low before the first clock. It shifts its bits out MSB first, changing data while the clock is low so the device can sample on the rising edge. It then drops chip select and holds it low for one bit period. `busyOut` covers the whole exchange. `doneOut` marks the cycle in which the block is free again. Every command opens with a start bit of 1. The two framing commands carry a 4-bit opcode followed by zero filler bits. The write command carries a 2-bit opcode, the address and the data.

Top module: `mwWriteSeq`

## Requirements
- R1: After reset `csOut`, `sclkOut`, `mosiOut`, `busyOut` and `doneOut` are all 0.
- R2: A `startIn` pulse while idle produces exactly three chip-select frames in the order write-enable, write, write-disable. `busyOut` and `csOut` rise in the cycle after the strobe.
- R3: The write-enable frame is the start bit 1, the opcode bits 0,0,1,1, then ADDR_W-3 zero filler bits, 2+ADDR_W bits in all.
- R4: The write-disable frame is the start bit 1, the opcode bits 0,0,0,0, then ADDR_W-3 zero filler bits.
- R5: The write frame is the start bit 1, the opcode bits 0,1, the address MSB first, then the data MSB first. The address and data are those present with the accepted strobe.
- R6: Each bit lasts 2*HALF_CYC cycles. `sclkOut` is low for the first HALF_CYC cycles and high for the last HALF_CYC cycles. `mosiOut` holds the bit for the whole period.
- R7: In each frame `csOut` is high with `sclkOut` low and `mosiOut` showing the first bit for SETTLE_CYC cycles before the first clock. After the last bit `csOut` is low for 2*HALF_CYC cycles before the next frame or the end.
- R8: `busyOut` stays high until the gap after the disable frame ends. `doneOut` is high for exactly one cycle, the first cycle with `busyOut` low. A new request may be accepted in that cycle.
- R9: A `startIn` pulse while `busyOut` is high is ignored. It changes neither the running exchange nor the behaviour after it.
- R10: Whenever `csOut` is low, `sclkOut` and `mosiOut` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | One-cycle request strobe |
| addrIn | input | ADDR_W (8) | Word address, captured with the strobe |
| dataIn | input | DATA_W (16) | Data word, captured with the strobe |
| busyOut | output | 1 | Request in progress |
| doneOut | output | 1 | One-cycle completion pulse |
| csOut | output | 1 | Serial chip select, active high |
| sclkOut | output | 1 | Serial clock |
| mosiOut | output | 1 | Serial data to the device |

## Verification
All outputs come directly from registers or from gates on registers. The first frame's chip select and start bit therefore appear in the first cycle after the edge that captures the strobe. From there each settle, bit and gap phase has a fixed length in cycles. The bench builds the expected cycle-by-cycle trace for a request the moment it drives the strobe, and compares every output against it between clock edges, one entry per cycle. The trace includes the done cycle, where a back-to-back strobe is accepted, and the idle cycles after an ignored strobe.

// File: rtl/mwWritePkg.sv
package mwWritePkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_SHIFT  = 2'd2,
    ST_GAP    = 2'd3
  } seqStateT;

  typedef enum logic [1:0] {
    FR_ENABLE  = 2'd0,
    FR_WRITE   = 2'd1,
    FR_DISABLE = 2'd2
  } frameKindT;

  // strobes from control to datapath
  typedef struct packed {
    logic      capture;   // latch host address and data
    logic      load;      // load a new frame into the shifter
    frameKindT kind;      // which frame to load
    logic      shift;     // advance to the next bit
  } dpCtlT;

endpackage

// File: rtl/mwWriteDp.sv
module mwWriteDp
  import mwWritePkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtlT             ctl,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              msbBit,
  output logic              lastBit
);
  localparam int FRAME_W = 3 + ADDR_W + DATA_W;
  localparam int CMD_LEN = 2 + ADDR_W;          // start + 4 opcode + ADDR_W-3 filler
  localparam int BIT_W   = $clog2(FRAME_W + 1);

  logic [ADDR_W-1:0]  addrQ;
  logic [DATA_W-1:0]  dataQ;
  logic [FRAME_W-1:0] shReg;
  logic [BIT_W-1:0]   bitsLeft;
  logic [FRAME_W-1:0] nextFrame;
  logic [BIT_W-1:0]   nextLen;

  always_comb begin
    unique case (ctl.kind)
      FR_WRITE: begin
        nextFrame = {3'b101, addrQ, dataQ};
        nextLen   = BIT_W'(FRAME_W);
      end
      FR_DISABLE: begin
        nextFrame = {5'b10000, {(FRAME_W-5){1'b0}}};
        nextLen   = BIT_W'(CMD_LEN);
      end
      default: begin
        nextFrame = {5'b10011, {(FRAME_W-5){1'b0}}};
        nextLen   = BIT_W'(CMD_LEN);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      dataQ    <= '0;
      shReg    <= '0;
      bitsLeft <= '0;
    end else begin
      if (ctl.capture) begin
        addrQ <= addrIn;
        dataQ <= dataIn;
      end
      if (ctl.load) begin
        shReg    <= nextFrame;
        bitsLeft <= nextLen;
      end else if (ctl.shift) begin
        shReg    <= {shReg[FRAME_W-2:0], 1'b0};
        bitsLeft <= bitsLeft - BIT_W'(1);
      end
    end
  end

  assign msbBit  = shReg[FRAME_W-1];
  assign lastBit = (bitsLeft == BIT_W'(1));

endmodule

// File: rtl/mwWriteCtrl.sv
module mwWriteCtrl
  import mwWritePkg::*;
#(
  parameter int HALF_CYC   = 2,
  parameter int SETTLE_CYC = 2
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  startIn,
  input  logic  lastBit,
  output dpCtlT ctl,
  output logic  busyOut,
  output logic  doneOut,
  output logic  csOut,
  output logic  sclkOut
);
  localparam int BIT_CYC = 2 * HALF_CYC;
  localparam int MAX_T   = (SETTLE_CYC > BIT_CYC) ? SETTLE_CYC : BIT_CYC;
  localparam int TIM_W   = $clog2(MAX_T + 1);

  seqStateT   state;
  frameKindT  frame;
  logic [TIM_W-1:0] timer;
  logic settleEnd, bitEnd;

  assign settleEnd = (timer == TIM_W'(SETTLE_CYC - 1));
  assign bitEnd    = (timer == TIM_W'(BIT_CYC - 1));

  always_comb begin
    ctl = '{capture: 1'b0, load: 1'b0, kind: FR_ENABLE, shift: 1'b0};
    unique case (state)
      ST_IDLE: if (startIn) begin
        ctl.capture = 1'b1;
        ctl.load    = 1'b1;
        ctl.kind    = FR_ENABLE;
      end
      ST_SHIFT: ctl.shift = bitEnd && !lastBit;
      ST_GAP: if (bitEnd && frame != FR_DISABLE) begin
        ctl.load = 1'b1;
        ctl.kind = (frame == FR_ENABLE) ? FR_WRITE : FR_DISABLE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      frame   <= FR_ENABLE;
      timer   <= '0;
      doneOut <= 1'b0;
    end else begin
      doneOut <= 1'b0;
      unique case (state)
        ST_IDLE: if (startIn) begin
          state <= ST_SETTLE;
          frame <= FR_ENABLE;
          timer <= '0;
        end
        ST_SETTLE: begin
          timer <= settleEnd ? '0 : timer + TIM_W'(1);
          if (settleEnd) state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          timer <= bitEnd ? '0 : timer + TIM_W'(1);
          if (bitEnd && lastBit) state <= ST_GAP;
        end
        ST_GAP: begin
          timer <= bitEnd ? '0 : timer + TIM_W'(1);
          if (bitEnd) begin
            if (frame == FR_DISABLE) begin
              state   <= ST_IDLE;
              doneOut <= 1'b1;
            end else begin
              state <= ST_SETTLE;
              frame <= ctl.kind;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busyOut = (state != ST_IDLE);
  assign csOut   = (state == ST_SETTLE) || (state == ST_SHIFT);
  assign sclkOut = (state == ST_SHIFT) && (timer >= TIM_W'(HALF_CYC));

endmodule

// File: rtl/mwWriteSeq.sv
module mwWriteSeq
  import mwWritePkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int HALF_CYC   = 2,
  parameter int SETTLE_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              busyOut,
  output logic              doneOut,
  output logic              csOut,
  output logic              sclkOut,
  output logic              mosiOut
);
  dpCtlT ctl;
  logic  msbBit, lastBit;

  mwWriteCtrl #(.HALF_CYC(HALF_CYC), .SETTLE_CYC(SETTLE_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .lastBit(lastBit),
    .ctl(ctl), .busyOut(busyOut), .doneOut(doneOut),
    .csOut(csOut), .sclkOut(sclkOut)
  );

  mwWriteDp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .addrIn(addrIn), .dataIn(dataIn),
    .msbBit(msbBit), .lastBit(lastBit)
  );

  assign mosiOut = csOut & msbBit;

endmodule

// File: rtl/mwWriteSeqChk.sv
module mwWriteSeqChk (
  input logic clk,
  input logic rstN,
  input logic startIn,
  input logic busyOut,
  input logic doneOut,
  input logic csOut,
  input logic sclkOut,
  input logic mosiOut
);
  AST_CS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !csOut |-> (!sclkOut && !mosiOut)); // R10
  AST_START_GO: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && !busyOut) |=> (busyOut && csOut)); // R2
  AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut); // R8
  AST_DONE_AT_FREE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneOut) |-> ($past(busyOut) && !busyOut)); // R8
  AST_CS_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    csOut |-> busyOut); // R8
  AST_DATA_AT_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclkOut) |-> $stable(mosiOut)); // R6
  AST_DATA_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sclkOut && $past(sclkOut)) |-> $stable(mosiOut)); // R6
endmodule

bind mwWriteSeq mwWriteSeqChk uChk (
  .clk(clk), .rstN(rstN), .startIn(startIn), .busyOut(busyOut),
  .doneOut(doneOut), .csOut(csOut), .sclkOut(sclkOut), .mosiOut(mosiOut)
);

// File: tb/mwWriteSeq_test.sv
module mwWriteSeq_test;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int HALF_CYC = 2;
  localparam int SETTLE_CYC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [DATA_W-1:0] dataIn = '0;
  logic busyOut, doneOut, csOut, sclkOut, mosiOut;

  int total = 0;
  int bad = 0;
  string idleTag = "R1";

  typedef struct {
    bit cs; bit sclk; bit mosi; bit busy; bit done;
    string tag;
  } expT;
  expT q[$];

  always #2.5 clk = ~clk;

  mwWriteSeq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HALF_CYC(HALF_CYC),
               .SETTLE_CYC(SETTLE_CYC)) uut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .addrIn(addrIn), .dataIn(dataIn),
    .busyOut(busyOut), .doneOut(doneOut), .csOut(csOut), .sclkOut(sclkOut),
    .mosiOut(mosiOut)
  );

  function automatic expT mk(bit cs, bit sclk, bit mosi, bit busy, bit done, string tag);
    expT e;
    e.cs = cs; e.sclk = sclk; e.mosi = mosi; e.busy = busy; e.done = done; e.tag = tag;
    return e;
  endfunction

  task automatic addFrame(input logic [63:0] v, input int n, input string tag);
    for (int i = 0; i < SETTLE_CYC; i++) q.push_back(mk(1, 0, v[n-1], 1, 0, "R7"));
    for (int b = n - 1; b >= 0; b--) begin
      for (int i = 0; i < HALF_CYC; i++) q.push_back(mk(1, 0, v[b], 1, 0, {tag, " R6"}));
      for (int i = 0; i < HALF_CYC; i++) q.push_back(mk(1, 1, v[b], 1, 0, {tag, " R6"}));
    end
    for (int i = 0; i < 2 * HALF_CYC; i++) q.push_back(mk(0, 0, 0, 1, 0, "R7 R10"));
  endtask

  task automatic addRequest(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    logic [63:0] wr;
    wr = (64'd5 << (ADDR_W + DATA_W)) | (64'(a) << DATA_W) | 64'(d);
    addFrame(64'h13 << (ADDR_W - 3), ADDR_W + 2, "R2 R3");
    addFrame(wr, 3 + ADDR_W + DATA_W, "R2 R5");
    addFrame(64'h10 << (ADDR_W - 3), ADDR_W + 2, "R2 R4");
    q.push_back(mk(0, 0, 0, 0, 1, "R8"));
  endtask

  task automatic cmp(input string name, input logic act, input bit exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, name, act, exp, $time);
    end
  endtask

  task automatic step(input bit doStart, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] d);
    expT e;
    @(negedge clk);
    if (q.size() > 0) e = q.pop_front();
    else e = mk(0, 0, 0, 0, 0, idleTag);
    cmp("cs", csOut, e.cs, e.tag);
    cmp("sclk", sclkOut, e.sclk, e.tag);
    cmp("mosi", mosiOut, e.mosi, e.tag);
    cmp("busy", busyOut, e.busy, e.tag);
    cmp("done", doneOut, e.done, e.tag);
    startIn = doStart;
    addrIn = a;
    dataIn = d;
    if (doStart && q.size() == 0) addRequest(a, d);
  endtask

  task automatic drain();
    while (q.size() > 0) step(0, '0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 idle after reset
    repeat (4) step(0, '0, '0);
    idleTag = "R10";
    // R2 R5 mixed pattern
    step(1, 8'hA5, 16'h5A3C);
    drain();
    // R9 strobe during busy is ignored
    step(1, 8'hFF, 16'hFFFF);
    repeat (30) step(0, '0, '0);
    step(1, 8'h12, 16'h3456);
    drain();
    idleTag = "R9";
    repeat (20) step(0, '0, '0);
    idleTag = "R10";
    // R8 back-to-back: strobe in the done cycle is accepted
    step(1, 8'h00, 16'h0000);
    while (q.size() > 1) step(0, '0, '0);
    step(1, 8'h3C, 16'h8001);
    drain();
    repeat (5) step(0, '0, '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule